// File: doc/BRIEF.md
# Multi-Mode Quadrature Position Counter

This block tracks the position of an incremental shaft encoder in a 24-bit up/down register. The two encoder phases pass through a two-flop synchroniser and are then decoded into count steps at one, two or four steps per phase cycle. In the plain pulse mode, phase A is a count clock and phase B sets the direction. A five-bit mode word selects the resolution, binary or packed-decimal counting, and one of four ways of handling the count limits: free wrap, clamp between zero and the preset, stop after the first wrap, or wrap at the preset.

Three single-cycle strobes act on the count register. One clears the count, one loads the count from the preset register, and one copies the count into an output latch that software or a bus bridge reads. A carry or borrow pulse marks each wrap, so a second instance can be clocked from it to build a longer count. An eight-bit status word gathers the sticky event flags.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset, the count, the preset, the output latch and the status word are all zero, and the carry and borrow pulses are low.
- R2: With mode[2:1]=00 in binary (mode[0]=0), an up step at 0xFFFFFF gives 0 and a down step at 0 gives 0xFFFFFF. Each such wrap raises carry_o (up) or borrow_o (down) for exactly one cycle, in the cycle the wrapped count appears. The two pulses are never high together.
- R3: With mode[0]=1, the count runs in packed decimal, one digit per nibble. An up step at 0x000009 gives 0x000010, a down step at 0x000010 gives 0x000009, and the free-wrap limit is 0x999999.
- R4: With mode[2:1]=01, an up step is ignored while the count equals the preset, and a down step is ignored while the count is 0. The opposite direction still counts, and blocked steps produce no carry or borrow.
- R5: With mode[2:1]=10, the step that wraps the count still gives its carry or borrow. After that, every step is ignored until a load or a count reset.
- R6: With mode[2:1]=11, an up step at the preset gives 0 with a carry, and a down step at 0 gives the preset with a borrow.
- R7: mode[4:3] picks the stepping. 00: each rising edge of A is one step, up when B is 1. 01, 10, 11: one full quadrature cycle gives 1, 2 or 4 steps. The count goes up when A leads B (phase pair BA sequence 00,01,11,10 read as A then B: 00→10→11→01).
- R8: In the quadrature modes, a sample in which both phases change sets the error flag and produces no step.
- R9: The status word holds borrow toggle in bit 0, carry toggle in bit 1, compare toggle in bit 2, sign in bit 3, error in bit 4 and last direction in bit 5 (1 = up). Bits 7:6 read 0. The toggles flip on each borrow, each carry, and each step that lands on the preset value. Sign is set by a borrow and cleared by a carry.
- R10: The count reset strobe sets the count to 0 and wins over the load strobe. Load copies the preset into the count. The latch strobe copies the count as it stood before that edge into latch_o. The preset changes only on preset_wr.
- R11: While count_en is 0, phase activity changes neither the count nor the error flag.
- R12: clear_flags clears status bits 4:0 at the next edge and leaves the count and bit 5 alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Encoder phase A, or the count clock in pulse mode |
| phase_b | input | 1 | Encoder phase B, or the direction in pulse mode |
| count_en | input | 1 | Enables phase decoding |
| mode | input | 5 | [0] decimal, [2:1] limit handling, [4:3] stepping |
| preset_in | input | 24 | Value for the preset register |
| preset_wr | input | 1 | Writes preset_in into the preset |
| load_cnt | input | 1 | Loads the count from the preset |
| latch_cnt | input | 1 | Copies the count to the output latch |
| reset_cnt | input | 1 | Clears the count |
| clear_flags | input | 1 | Clears the sticky status bits |
| count_o | output | 24 | Current count |
| latch_o | output | 24 | Output latch |
| carry_o | output | 1 | One-cycle pulse on an up wrap |
| borrow_o | output | 1 | One-cycle pulse on a down wrap |
| status_o | output | 8 | Status word |

## Verification
The checks on the strobes assume each strobe lasts one cycle. The check on the stopped state assumes the limit mode is not changed while the counter is stopped after a wrap. The stimulus clears a stopped counter with a load before it switches modes, and holds every phase level for four clocks, so that no two phase changes fall inside one synchronised sample except in the deliberate error case. Preset values used in decimal mode are themselves valid decimal numbers.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef enum logic [1:0] {
    BND_FREE    = 2'b00,
    BND_CLAMP   = 2'b01,
    BND_ONESHOT = 2'b10,
    BND_MODN    = 2'b11
  } bound_e;

  typedef enum logic [1:0] {
    SCL_PULSE = 2'b00,
    SCL_X1    = 2'b01,
    SCL_X2    = 2'b10,
    SCL_X4    = 2'b11
  } scale_e;

  typedef struct packed {
    logic step;
    logic up;
    logic err;
  } qev_t;
endpackage

// File: rtl/qpc_edge_decode.sv
module qpc_edge_decode
  import qpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   phase_a,
  input  logic   phase_b,
  input  scale_e scale,
  output qev_t   ev
);
  logic [SYNC_STAGES-1:0] sa_q, sb_q;
  logic a_prev_q, b_prev_q;
  logic a_s, b_s, ch_a, ch_b, fwd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q     <= '0;
      sb_q     <= '0;
      a_prev_q <= 1'b0;
      b_prev_q <= 1'b0;
    end else begin
      sa_q     <= {sa_q[SYNC_STAGES-2:0], phase_a};
      sb_q     <= {sb_q[SYNC_STAGES-2:0], phase_b};
      a_prev_q <= sa_q[SYNC_STAGES-1];
      b_prev_q <= sb_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    a_s  = sa_q[SYNC_STAGES-1];
    b_s  = sb_q[SYNC_STAGES-1];
    ch_a = a_s ^ a_prev_q;
    ch_b = b_s ^ b_prev_q;
    fwd  = a_s ^ b_prev_q;
    ev   = '0;
    unique case (scale)
      SCL_PULSE: begin
        ev.step = a_s & ~a_prev_q;
        ev.up   = b_s;
      end
      SCL_X1: begin
        ev.err  = ch_a & ch_b;
        ev.step = ch_a & ~ch_b & (fwd ? a_s : ~a_s);
        ev.up   = fwd;
      end
      SCL_X2: begin
        ev.err  = ch_a & ch_b;
        ev.step = ch_a & ~ch_b;
        ev.up   = fwd;
      end
      default: begin
        ev.err  = ch_a & ch_b;
        ev.step = ch_a ^ ch_b;
        ev.up   = fwd;
      end
    endcase
  end
endmodule

// File: rtl/qpc_step_core.sv
// Next-count logic; CW must be a multiple of 4 for decimal mode.
module qpc_step_core
  import qpc_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] preset,
  input  logic          dec_mode,
  input  bound_e        bnd,
  input  logic          step,
  input  logic          up,
  input  logic          halted,
  output logic [CW-1:0] nxt,
  output logic          moved,
  output logic          wrap_up,
  output logic          wrap_dn
);
  localparam int ND = CW / 4;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v, input logic dm, input logic inc);
    logic [CW-1:0] r;
    logic          c;
    logic [3:0]    nib;
    if (!dm) begin
      r = inc ? v + 1'b1 : v - 1'b1;
    end else begin
      r = v;
      c = 1'b1;
      for (int d = 0; d < ND; d++) begin
        nib = v[4*d +: 4];
        if (c) begin
          if (inc) begin
            if (nib >= 4'd9) r[4*d +: 4] = 4'd0;
            else begin r[4*d +: 4] = nib + 4'd1; c = 1'b0; end
          end else begin
            if (nib == 4'd0) r[4*d +: 4] = 4'd9;
            else begin r[4*d +: 4] = nib - 4'd1; c = 1'b0; end
          end
        end
      end
    end
    return r;
  endfunction

  logic [CW-1:0] top_val, max_val;

  always_comb begin
    max_val = dec_mode ? {ND{4'h9}} : {CW{1'b1}};
    top_val = (bnd == BND_MODN) ? preset : max_val;
    nxt     = cnt;
    moved   = 1'b0;
    wrap_up = 1'b0;
    wrap_dn = 1'b0;
    if (step && !(bnd == BND_ONESHOT && halted)) begin
      if (up) begin
        if (!(bnd == BND_CLAMP && cnt == preset)) begin
          moved = 1'b1;
          if (cnt == top_val) begin
            nxt     = '0;
            wrap_up = 1'b1;
          end else begin
            nxt = bump(cnt, dec_mode, 1'b1);
          end
        end
      end else begin
        if (!(bnd == BND_CLAMP && cnt == '0)) begin
          moved = 1'b1;
          if (cnt == '0) begin
            nxt     = top_val;
            wrap_dn = 1'b1;
          end else begin
            nxt = bump(cnt, dec_mode, 1'b0);
          end
        end
      end
    end
  end
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CW          = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_a,
  input  logic          phase_b,
  input  logic          count_en,
  input  logic [4:0]    mode,
  input  logic [CW-1:0] preset_in,
  input  logic          preset_wr,
  input  logic          load_cnt,
  input  logic          latch_cnt,
  input  logic          reset_cnt,
  input  logic          clear_flags,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] latch_o,
  output logic          carry_o,
  output logic          borrow_o,
  output logic [7:0]    status_o
);
  bound_e bnd;
  scale_e scl;
  qev_t   ev;
  logic   step_ok, err_ok, core_step;
  logic [CW-1:0] core_nxt;
  logic   moved, wrap_up, wrap_dn;

  logic [CW-1:0] cnt_q, cnt_d, preset_q, preset_d, latch_q, latch_d;
  logic halted_q, halted_d, carry_q, carry_d, borrow_q, borrow_d;
  logic bt_q, bt_d, ct_q, ct_d, cmp_q, cmp_d, sgn_q, sgn_d, err_q, err_d, dir_q, dir_d;

  assign bnd = bound_e'(mode[2:1]);
  assign scl = scale_e'(mode[4:3]);

  qpc_edge_decode #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .scale(scl), .ev(ev)
  );

  assign step_ok   = ev.step & count_en;
  assign err_ok    = ev.err & count_en;
  assign core_step = step_ok & ~reset_cnt & ~load_cnt;

  qpc_step_core #(.CW(CW)) u_core (
    .cnt(cnt_q), .preset(preset_q), .dec_mode(mode[0]), .bnd(bnd),
    .step(core_step), .up(ev.up), .halted(halted_q),
    .nxt(core_nxt), .moved(moved), .wrap_up(wrap_up), .wrap_dn(wrap_dn)
  );

  always_comb begin
    if (reset_cnt)      cnt_d = '0;
    else if (load_cnt)  cnt_d = preset_q;
    else if (moved)     cnt_d = core_nxt;
    else                cnt_d = cnt_q;

    if (reset_cnt || load_cnt)                        halted_d = 1'b0;
    else if (bnd == BND_ONESHOT && (wrap_up || wrap_dn)) halted_d = 1'b1;
    else                                              halted_d = halted_q;

    preset_d = preset_wr ? preset_in : preset_q;
    latch_d  = latch_cnt ? cnt_q : latch_q;
    carry_d  = wrap_up;
    borrow_d = wrap_dn;
    dir_d    = step_ok ? ev.up : dir_q;

    if (clear_flags) begin
      bt_d  = 1'b0;
      ct_d  = 1'b0;
      cmp_d = 1'b0;
      sgn_d = 1'b0;
      err_d = 1'b0;
    end else begin
      bt_d  = bt_q ^ wrap_dn;
      ct_d  = ct_q ^ wrap_up;
      cmp_d = cmp_q ^ (moved && (core_nxt == preset_q));
      sgn_d = wrap_dn ? 1'b1 : (wrap_up ? 1'b0 : sgn_q);
      err_d = err_q | err_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      preset_q <= '0;
      latch_q  <= '0;
      halted_q <= 1'b0;
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
      bt_q     <= 1'b0;
      ct_q     <= 1'b0;
      cmp_q    <= 1'b0;
      sgn_q    <= 1'b0;
      err_q    <= 1'b0;
      dir_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      preset_q <= preset_d;
      latch_q  <= latch_d;
      halted_q <= halted_d;
      carry_q  <= carry_d;
      borrow_q <= borrow_d;
      bt_q     <= bt_d;
      ct_q     <= ct_d;
      cmp_q    <= cmp_d;
      sgn_q    <= sgn_d;
      err_q    <= err_d;
      dir_q    <= dir_d;
    end
  end

  assign count_o  = cnt_q;
  assign latch_o  = latch_q;
  assign carry_o  = carry_q;
  assign borrow_o = borrow_q;
  assign status_o = {2'b00, dir_q, err_q, sgn_q, cmp_q, ct_q, bt_q};
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_cnt,
  input logic          latch_cnt,
  input logic          reset_cnt,
  input logic          clear_flags,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] latch_o,
  input logic          carry_o,
  input logic          borrow_o,
  input logic [7:0]    status_o,
  input logic [CW-1:0] preset_q,
  input logic          halted_q
);
  assert_pulse_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_o && borrow_o));

  assert_carry_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> (count_o == '0));

  assert_reset_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cnt |=> (count_o == '0));

  assert_load_preset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_cnt && !reset_cnt) |=> (count_o == $past(preset_q)));

  assert_latch_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    latch_cnt |=> (latch_o == $past(count_o)));

  assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !load_cnt && !reset_cnt) |=> $stable(count_o));

  assert_flag_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clear_flags |=> (status_o[4:0] == 5'b0));
endmodule

bind quad_pos_counter qpc_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_cnt(load_cnt), .latch_cnt(latch_cnt),
  .reset_cnt(reset_cnt), .clear_flags(clear_flags), .count_o(count_o),
  .latch_o(latch_o), .carry_o(carry_o), .borrow_o(borrow_o),
  .status_o(status_o), .preset_q(preset_q), .halted_q(halted_q)
);

// File: tb/quad_pos_counter_test.sv
module quad_pos_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_a = 1'b0, phase_b = 1'b0, count_en = 1'b0;
  logic [4:0]  mode = 5'h00;
  logic [23:0] preset_in = '0;
  logic        preset_wr = 1'b0, load_cnt = 1'b0, latch_cnt = 1'b0;
  logic        reset_cnt = 1'b0, clear_flags = 1'b0;
  logic [23:0] count_o, latch_o;
  logic        carry_o, borrow_o;
  logic [7:0]  status_o;

  quad_pos_counter uut (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .count_en(count_en), .mode(mode), .preset_in(preset_in),
    .preset_wr(preset_wr), .load_cnt(load_cnt), .latch_cnt(latch_cnt),
    .reset_cnt(reset_cnt), .clear_flags(clear_flags), .count_o(count_o),
    .latch_o(latch_o), .carry_o(carry_o), .borrow_o(borrow_o),
    .status_o(status_o)
  );

  always #10 clk = ~clk;

  typedef struct {
    string       tag;
    logic [23:0] cnt;
    logic        chk_l;
    logic [23:0] lat;
    logic [7:0]  st;
    logic [7:0]  msk;
    int          car;
    int          bor;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  int obs_car = 0, obs_bor = 0, exp_car = 0, exp_bor = 0;
  int idx = 0;
  bit done = 0;

  // monitor: counts pulses and compares queued expectations
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (carry_o)  obs_car++;
      if (borrow_o) obs_bor++;
    end
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (count_o !== e.cnt || (e.chk_l && latch_o !== e.lat) ||
          ((status_o & e.msk) !== (e.st & e.msk)) ||
          obs_car != e.car || obs_bor != e.bor) begin
        errors++;
        $display("FAIL %s: cnt=%h/%h lat=%h/%h st=%h/%h(m%h) car=%0d/%0d bor=%0d/%0d",
                 e.tag, count_o, e.cnt, latch_o, e.lat, status_o, e.st, e.msk,
                 obs_car, e.car, obs_bor, e.bor);
      end
    end
  end

  task automatic expect_st(input string tag, input logic [23:0] c,
                           input logic [7:0] st, input logic [7:0] msk,
                           input logic chk_l = 1'b0, input logic [23:0] lat = '0);
    exp_t e;
    e.tag = tag; e.cnt = c; e.chk_l = chk_l; e.lat = lat;
    e.st = st; e.msk = msk; e.car = exp_car; e.bor = exp_bor;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic drive_ab(input logic a, input logic b);
    phase_a = a; phase_b = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic fwd(input int n);
    for (int i = 0; i < n; i++) begin
      idx = (idx + 1) % 4;
      drive_ab(idx == 1 || idx == 2, idx == 2 || idx == 3);
    end
  endtask

  task automatic back(input int n);
    for (int i = 0; i < n; i++) begin
      idx = (idx + 3) % 4;
      drive_ab(idx == 1 || idx == 2, idx == 2 || idx == 3);
    end
  endtask

  task automatic npulse(input int n);
    for (int i = 0; i < n; i++) begin
      drive_ab(1'b1, phase_b);
      drive_ab(1'b0, phase_b);
    end
  endtask

  task automatic strobe(input bit rc, input bit ld, input bit lt, input bit cf, input bit pw);
    reset_cnt = rc; load_cnt = ld; latch_cnt = lt; clear_flags = cf; preset_wr = pw;
    @(negedge clk);
    reset_cnt = 0; load_cnt = 0; latch_cnt = 0; clear_flags = 0; preset_wr = 0;
    @(negedge clk);
  endtask

  task automatic wr_preset(input logic [23:0] v);
    preset_in = v;
    strobe(0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_st("R1 reset state", 24'h0, 8'h00, 8'hFF, 1'b1, 24'h0);

    count_en = 1'b1;
    mode = 5'h18;                                  // X4, free wrap, binary
    fwd(4);  expect_st("R7 X4 four steps", 24'h4, 8'h20, 8'h3F);
    back(5); exp_bor++;
    expect_st("R2 underflow borrow", 24'hFFFFFF, 8'h0D, 8'h3F);
    fwd(1);  exp_car++;
    expect_st("R9 overflow carry flags", 24'h0, 8'h23, 8'h3F);
    strobe(0, 0, 0, 1, 0);
    expect_st("R12 clear flags", 24'h0, 8'h20, 8'hFF);

    mode = 5'h10;                                  // X2
    fwd(4);  expect_st("R7 X2 cycle", 24'h2, 8'h00, 8'h00);
    mode = 5'h08;                                  // X1
    fwd(4);  expect_st("R7 X1 cycle up", 24'h3, 8'h00, 8'h00);
    back(4); expect_st("R7 X1 cycle down", 24'h2, 8'h00, 8'h00);

    mode = 5'h18;
    drive_ab(1'b1, 1'b1);
    drive_ab(1'b0, 1'b0);
    expect_st("R8 double change error", 24'h2, 8'h10, 8'h10);
    strobe(0, 0, 0, 1, 0);

    count_en = 1'b0;
    fwd(4);
    expect_st("R11 disabled no count", 24'h2, 8'h00, 8'h10);
    count_en = 1'b1;

    mode = 5'h00;                                  // pulse mode
    drive_ab(1'b0, 1'b1);
    npulse(3); expect_st("R7 pulse up", 24'h5, 8'h20, 8'h20);
    drive_ab(1'b0, 1'b0);
    npulse(2); expect_st("R7 pulse down", 24'h3, 8'h00, 8'h20);
    idx = 0;

    mode = 5'h18;
    wr_preset(24'h000010);
    strobe(0, 1, 0, 0, 0);
    expect_st("R10 load preset", 24'h10, 8'h00, 8'h00);
    strobe(0, 0, 1, 0, 0);
    expect_st("R10 latch count", 24'h10, 8'h00, 8'h00, 1'b1, 24'h10);
    strobe(1, 1, 0, 0, 0);
    expect_st("R10 reset beats load", 24'h0, 8'h00, 8'h00, 1'b1, 24'h10);

    mode = 5'h1E;                                  // modulo
    wr_preset(24'h3);
    strobe(1, 0, 0, 1, 0);
    fwd(4);  exp_car++;
    expect_st("R6 modulo up wrap", 24'h0, 8'h06, 8'h07);
    back(1); exp_bor++;
    expect_st("R6 modulo down reload", 24'h3, 8'h03, 8'h07);

    mode = 5'h1A;                                  // clamp
    strobe(1, 0, 0, 0, 0);
    fwd(6);  expect_st("R4 clamp at preset", 24'h3, 8'h00, 8'h00);
    back(5); expect_st("R4 clamp at zero", 24'h0, 8'h00, 8'h00);

    mode = 5'h1C;                                  // stop after wrap
    wr_preset(24'hFFFFFE);
    strobe(0, 1, 0, 0, 0);
    fwd(3);  exp_car++;
    expect_st("R5 stop after carry", 24'h0, 8'h00, 8'h00);
    back(2); expect_st("R5 stays stopped", 24'h0, 8'h00, 8'h00);
    strobe(0, 1, 0, 0, 0);
    fwd(1);  expect_st("R5 load re-enables", 24'hFFFFFF, 8'h00, 8'h00);

    mode = 5'h19;                                  // decimal, free wrap
    wr_preset(24'h999998);
    strobe(0, 1, 0, 0, 0);
    fwd(2);  exp_car++;
    expect_st("R3 decimal overflow", 24'h0, 8'h00, 8'h00);
    back(1); exp_bor++;
    expect_st("R3 decimal underflow", 24'h999999, 8'h00, 8'h00);
    wr_preset(24'h000009);
    strobe(0, 1, 0, 0, 0);
    fwd(1);  expect_st("R3 digit carry up", 24'h000010, 8'h00, 8'h00);
    back(1); expect_st("R3 digit borrow down", 24'h000009, 8'h00, 8'h00);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule